// File: doc/BRIEF.md
# Host tagged FIFO channel pair

This block joins a host to an accelerator fabric through two queues running in opposite directions. The inbound queue carries host-to-fabric words. Each inbound word is 32 bits wide and travels with a 4-bit tag. The outbound queue carries fabric-to-host words of 32 bits. Each queue holds 512 entries. Both queues run on a single clock, the memory-side clock, so the block contains no clock-domain crossing.

The host writes the inbound queue and drains the outbound queue through valid/ready handshakes. It can also poll a fill count for each queue. The fabric sees two status lines, inbound-empty and outbound-full, and drives two strobes, inbound-read and outbound-write. All four of these fabric-side lines are active-low.

A fabric read returns data and tag from a register one edge after the strobe. A fabric read of an empty inbound queue, or a fabric write to a full outbound queue, is dropped and latches a sticky error flag. Only reset clears these flags.

Top module: `hft_channel_pair`

## Requirements
- R1: After a synchronous active-low reset, both counts are 0, `fab_in_empty_n` is 0, `fab_out_full_n` is 1, `h_out_valid` is 0, `h_in_ready` is 1, and both error flags are 0.
- R2: When `h_in_valid` and `h_in_ready` are both high at an edge, the data and tag are stored as one entry, and `h_in_count` rises by one after that edge.
- R3: When `fab_in_rd_n` is low at an edge and the inbound queue is not empty, `fab_in_data` and `fab_in_tag` show the oldest stored word and its tag after that edge. Words come out in the order they were written. Both outputs hold their values while no read takes place.
- R4: `fab_in_empty_n` is 0 exactly when `h_in_count` is 0.
- R5: A fabric read while the inbound queue is empty is ignored: the count stays 0 and `fab_in_data` is unchanged. The read sets `fab_underflow_err`, which stays set until reset.
- R6: When `fab_out_wr_n` is low at an edge and the outbound queue is not full, `fab_out_data` is stored. The host sees the oldest stored word on `h_out_data` while `h_out_valid` is high, and `h_out_ready` removes that word at the edge.
- R7: `fab_out_full_n` is 0 exactly when `h_out_count` is 512. `h_in_ready` is 0 exactly when `h_in_count` is 512, and a host push while `h_in_ready` is 0 is not stored.
- R8: A fabric write while the outbound queue is full is ignored: the count stays 512 and the stored contents are unchanged. The write sets `fab_overflow_err`, which stays set until reset.
- R9: A push and a pop on the same queue at the same edge leave its count unchanged.
- R10: A reset taken while the queues hold data and the error flags are set empties both queues and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock shared by both queues |
| rst_n | input | 1 | Synchronous reset, active low |
| h_in_valid | input | 1 | Host offers an inbound word |
| h_in_ready | output | 1 | Inbound queue can accept a word |
| h_in_data | input | 32 | Inbound data word |
| h_in_tag | input | 4 | Tag stored with the inbound word |
| h_in_count | output | 10 | Inbound occupancy |
| h_out_valid | output | 1 | Outbound word available to host |
| h_out_ready | input | 1 | Host takes the outbound word |
| h_out_data | output | 32 | Oldest outbound word |
| h_out_count | output | 10 | Outbound occupancy |
| fab_in_empty_n | output | 1 | Inbound queue empty, active low |
| fab_in_rd_n | input | 1 | Fabric read strobe, active low |
| fab_in_data | output | 32 | Registered inbound data |
| fab_in_tag | output | 4 | Registered inbound tag |
| fab_out_full_n | output | 1 | Outbound queue full, active low |
| fab_out_wr_n | input | 1 | Fabric write strobe, active low |
| fab_out_data | input | 32 | Outbound data from fabric |
| fab_underflow_err | output | 1 | Sticky: a fabric read found the inbound queue empty |
| fab_overflow_err | output | 1 | Sticky: a fabric write found the outbound queue full |

## Verification
The hardest states to reach are the full boundaries of the two 512-entry queues. Only there can an outbound overflow be attempted and the host stalled. To reach them, the bench holds the write strobe for 512 consecutive cycles and then adds one more write of a distinct marker value. It then drains the first entry to show that the marker never entered the queue and that the order is intact. The inbound queue is filled the same way through the host port, with `h_in_valid` held high for an extra cycle past full.

// File: rtl/hft_pkg.sv
// Package: default geometry shared by the channel pair and its bench.
// Assumes the queue depth is a power of two.
package hft_pkg;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_TAG_W  = 4;
    localparam int unsigned DEF_DEPTH  = 512;
endpackage

// File: rtl/hft_fifo_core.sv
// Module: single-clock circular queue with combinational head output.
// Assumes the caller never pushes when full nor pops when empty; DEPTH is a power of two.
module hft_fifo_core #(
    parameter int unsigned W     = 36,
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer advance on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + AW'(1);
            if (pop)  rd_ptr <= rd_ptr + AW'(1);
        end
    end

    // Occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Status and head decode.
    always_comb begin
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
        head  = mem[rd_ptr];
    end

    a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push) else $error("push while full");
    a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop) else $error("pop while empty");
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count)) else $error("count moved on push+pop");
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + CW'(1))) else $error("count step");
endmodule

// File: rtl/hft_fabric_rd_port.sv
// Module: fabric-side read port; turns the active-low read strobe into a pop,
// registers the head word, and latches a sticky error on reads of an empty queue.
// Assumes head is valid whenever empty is low.
module hft_fabric_rd_port #(
    parameter int unsigned W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_n,
    input  logic         empty,
    input  logic [W-1:0] head,
    output logic         pop,
    output logic [W-1:0] q,
    output logic         underflow_err
);
    // Qualify the strobe against the empty status.
    always_comb pop = !rd_n && !empty;

    // Output register loaded only on a real read.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (pop) q <= head;
    end

    // Sticky underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                underflow_err <= 1'b0;
        else if (!rd_n && empty)   underflow_err <= 1'b1;
    end

    a_r5_sticky_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err) else $error("underflow flag dropped");
    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> $stable(q)) else $error("read data moved without read");
endmodule

// File: rtl/hft_fabric_wr_port.sv
// Module: fabric-side write port; turns the active-low write strobe into a push
// and latches a sticky error on writes to a full queue.
module hft_fabric_wr_port (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic full,
    output logic push,
    output logic overflow_err
);
    // Qualify the strobe against the full status.
    always_comb push = !wr_n && !full;

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)             overflow_err <= 1'b0;
        else if (!wr_n && full) overflow_err <= 1'b1;
    end

    a_r8_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err) else $error("overflow flag dropped");
endmodule

// File: rtl/hft_channel_pair.sv
// Module: inbound tagged queue (host->fabric) and outbound queue (fabric->host)
// on one clock. Host side uses valid/ready; fabric side uses active-low lines.
module hft_channel_pair
    import hft_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned TAG_W  = DEF_TAG_W,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned IN_W  = DATA_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_in_valid,
    output logic              h_in_ready,
    input  logic [DATA_W-1:0] h_in_data,
    input  logic [TAG_W-1:0]  h_in_tag,
    output logic [CNT_W-1:0]  h_in_count,
    output logic              h_out_valid,
    input  logic              h_out_ready,
    output logic [DATA_W-1:0] h_out_data,
    output logic [CNT_W-1:0]  h_out_count,
    output logic              fab_in_empty_n,
    input  logic              fab_in_rd_n,
    output logic [DATA_W-1:0] fab_in_data,
    output logic [TAG_W-1:0]  fab_in_tag,
    output logic              fab_out_full_n,
    input  logic              fab_out_wr_n,
    input  logic [DATA_W-1:0] fab_out_data,
    output logic              fab_underflow_err,
    output logic              fab_overflow_err
);
    logic             in_push, in_pop, in_empty, in_full;
    logic [IN_W-1:0]  in_head, in_q;
    logic             out_push, out_pop, out_empty, out_full;

    // Host-side handshake decode.
    always_comb begin
        h_in_ready     = !in_full;
        in_push        = h_in_valid && !in_full;
        h_out_valid    = !out_empty;
        out_pop        = h_out_ready && !out_empty;
        fab_in_empty_n = !in_empty;
        fab_out_full_n = !out_full;
        fab_in_data    = in_q[DATA_W-1:0];
        fab_in_tag     = in_q[IN_W-1:DATA_W];
    end

    hft_fifo_core #(.W(IN_W), .DEPTH(DEPTH)) in_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(in_push), .wdata({h_in_tag, h_in_data}),
        .pop(in_pop), .head(in_head),
        .empty(in_empty), .full(in_full), .count(h_in_count)
    );

    hft_fabric_rd_port #(.W(IN_W)) in_rd_i (
        .clk(clk), .rst_n(rst_n),
        .rd_n(fab_in_rd_n), .empty(in_empty), .head(in_head),
        .pop(in_pop), .q(in_q), .underflow_err(fab_underflow_err)
    );

    hft_fifo_core #(.W(DATA_W), .DEPTH(DEPTH)) out_q_i (
        .clk(clk), .rst_n(rst_n),
        .push(out_push), .wdata(fab_out_data),
        .pop(out_pop), .head(h_out_data),
        .empty(out_empty), .full(out_full), .count(h_out_count)
    );

    hft_fabric_wr_port out_wr_i (
        .clk(clk), .rst_n(rst_n),
        .wr_n(fab_out_wr_n), .full(out_full),
        .push(out_push), .overflow_err(fab_overflow_err)
    );

    a_r4_empty_status: assert property (@(posedge clk) disable iff (!rst_n)
        (h_in_count == '0) |-> !fab_in_empty_n) else $error("empty status");
    a_r7_host_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (h_in_count == CNT_W'(DEPTH)) |-> !h_in_ready) else $error("ready while full");
endmodule

// File: tb/hft_channel_pair_tb_top.sv
module hft_channel_pair_tb_top;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        h_in_valid, h_in_ready;
    logic [31:0] h_in_data;
    logic [3:0]  h_in_tag;
    logic [9:0]  h_in_count;
    logic        h_out_valid, h_out_ready;
    logic [31:0] h_out_data;
    logic [9:0]  h_out_count;
    logic        fab_in_empty_n, fab_in_rd_n;
    logic [31:0] fab_in_data;
    logic [3:0]  fab_in_tag;
    logic        fab_out_full_n, fab_out_wr_n;
    logic [31:0] fab_out_data;
    logic        fab_underflow_err, fab_overflow_err;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hft_channel_pair dut_i (.*);

    // Stimulus table: {tag, data}
    localparam logic [35:0] VECS [8] = '{
        {4'h1, 32'h0000_0001}, {4'hF, 32'hFFFF_FFFF}, {4'h0, 32'h0000_0000},
        {4'hA, 32'hA5A5_A5A5}, {4'h5, 32'h5A5A_5A5A}, {4'h8, 32'h8000_0000},
        {4'h3, 32'h1234_5678}, {4'hC, 32'hDEAD_BEEF}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        h_in_valid = 0; h_in_data = 0; h_in_tag = 0; h_out_ready = 0;
        fab_in_rd_n = 1; fab_out_wr_n = 1; fab_out_data = 0;
        #1;
        do_reset();

        // R1 reset state
        chk("R1 in_count", h_in_count, 0);
        chk("R1 out_count", h_out_count, 0);
        chk("R1 empty_n", fab_in_empty_n, 0);
        chk("R1 full_n", fab_out_full_n, 1);
        chk("R1 out_valid", h_out_valid, 0);
        chk("R1 in_ready", h_in_ready, 1);
        chk("R1 errs", {fab_underflow_err, fab_overflow_err}, 0);

        // Table walk: host pushes, fabric reads (R2, R3, R4)
        foreach (VECS[i]) begin
            h_in_valid = 1; h_in_tag = VECS[i][35:32]; h_in_data = VECS[i][31:0];
            step();
            chk("R2 count", h_in_count, i + 1);
        end
        h_in_valid = 0;
        chk("R4 not empty", fab_in_empty_n, 1);
        foreach (VECS[i]) begin
            fab_in_rd_n = 0;
            step();
            fab_in_rd_n = 1;
            chk("R3 data", fab_in_data, VECS[i][31:0]);
            chk("R3 tag", fab_in_tag, VECS[i][35:32]);
            step();
            chk("R3 hold", fab_in_data, VECS[i][31:0]);
        end
        chk("R4 empty", fab_in_empty_n, 0);

        // Table walk on outbound path (R6)
        foreach (VECS[i]) begin
            fab_out_wr_n = 0; fab_out_data = VECS[i][31:0];
            step();
        end
        fab_out_wr_n = 1;
        chk("R6 count", h_out_count, 8);
        foreach (VECS[i]) begin
            chk("R6 valid", h_out_valid, 1);
            chk("R6 data", h_out_data, VECS[i][31:0]);
            h_out_ready = 1;
            step();
            h_out_ready = 0;
        end
        chk("R6 drained", h_out_valid, 0);

        // R5 underflow
        fab_in_rd_n = 0;
        step();
        fab_in_rd_n = 1;
        chk("R5 count", h_in_count, 0);
        chk("R5 data kept", fab_in_data, 32'hDEAD_BEEF);
        chk("R5 flag", fab_underflow_err, 1);
        step(); step();
        chk("R5 sticky", fab_underflow_err, 1);

        // R9 simultaneous push and pop
        h_in_valid = 1; h_in_tag = 4'h2; h_in_data = 32'h11;
        step();
        h_in_data = 32'h22; fab_in_rd_n = 0;
        step();
        h_in_valid = 0; fab_in_rd_n = 1;
        chk("R9 in_count", h_in_count, 1);
        chk("R9 read data", fab_in_data, 32'h11);

        // R7/R8 fill outbound
        for (int k = 0; k < DEPTH; k++) begin
            fab_out_wr_n = 0; fab_out_data = k;
            step();
        end
        chk("R7 full_n", fab_out_full_n, 0);
        chk("R7 out_count", h_out_count, DEPTH);
        fab_out_data = 32'hBAD0_BAD0;
        step();
        fab_out_wr_n = 1;
        chk("R8 count", h_out_count, DEPTH);
        chk("R8 flag", fab_overflow_err, 1);
        chk("R8 head", h_out_data, 0);
        h_out_ready = 1;
        step();
        h_out_ready = 0;
        chk("R8 next", h_out_data, 1);
        chk("R7 full_n release", fab_out_full_n, 1);

        // R7 inbound fill stalls host (one word already inside)
        h_in_valid = 1;
        for (int k = 1; k < DEPTH; k++) begin
            h_in_data = k;
            step();
        end
        chk("R7 in_ready", h_in_ready, 0);
        chk("R7 in_count", h_in_count, DEPTH);
        h_in_data = 32'hFEED;
        step();
        h_in_valid = 0;
        chk("R7 no push", h_in_count, DEPTH);

        // R10 reset clears all
        do_reset();
        chk("R10 in_count", h_in_count, 0);
        chk("R10 out_count", h_out_count, 0);
        chk("R10 flags", {fab_underflow_err, fab_overflow_err}, 0);
        chk("R10 empty_n", fab_in_empty_n, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule